// File: doc/BRIEF.md
# PHY Register Bank with Ping Timer

This block is the byte-wide register bank of a serial-bus physical layer. A link-request decoder reaches it with single-cycle read and write strobes on a 4-bit address. The bank reports what the PHY core knows: the node number, whether the node is root, cable power, the per-port line status, the connection state and the speed of each port. It also holds the controls that the core acts on: gap count, root-holding, the two bus-reset requests and slow mode. Two sticky interrupt flags and a 16-bit ping timer complete the bank.

The register bits change over time on their own. Both reset-request bits clear themselves when the core reports a completed bus reset. The interrupt flags are set by core events and cleared when software writes a 1. The ping timer is a three-state machine. From PT_IDLE the transition "start" (configuration packet sent) goes to PT_RUN. In PT_RUN, "restart" (another configuration packet) stays in PT_RUN with the count cleared, and "stop" (first packet received) goes to PT_HELD. From PT_HELD, "rearm" (configuration packet) returns to PT_RUN. While the state is PT_RUN the count advances on each 50 MHz tick.

Register layout, byte-wide, bit 7 first:
- 0x0 {node_id[5:0], root, cable_power}
- 0x1 {gap[5:0], hold_root, bus_reset_req}
- 0x2 {speed[1:0], 0, port_count[4:0]}
- 0x3 to 0x5 are port 0 to port 2, each {a[1:0], b[1:0], child, connected, fast, 0}
- 0x6 {loop_int, power_int, cable_power, 00000}
- 0x7 {slow_pin_low, slow_bit, arb_reset_req, 00000}
- 0x8 ping high byte
- 0x9 ping low byte

Top module: `phy_regbank`

## Requirements
- R1: After reset, rd_data is 0x00, gap_count is 0x3F, hold_root, bus_reset_req, arb_reset_req and slow_mode are 0, both interrupt flags are 0 and the ping timer reads 0.
- R2: A read strobe loads rd_data at the next clock edge with the addressed byte, and rd_data holds that value until the next read strobe. Address 0x1 is writable: gap count in bits 7:2, hold-root in bit 1, bus-reset request in bit 0.
- R3: bus_reset_req (0x1 bit 0) and arb_reset_req (0x7 bit 5) clear on a bus_reset_done pulse. A write to the same register in that cycle takes effect instead.
- R4: The speed field (0x2 bits 7:6) reads 01, or 00 while slow mode is active. Slow mode is active when the slow bit is 1 or slow_pin_n is low. The port-count field (0x2 bits 4:0) reads 3.
- R5: The slow bit (0x7 bit 6) is writable. The inverted slow pin reads at 0x7 bit 7. The arbitrated-reset request (0x7 bit 5) is writable.
- R6: Port n reads at 0x3+n as {a[1:0], b[1:0], child, connected, fast, 0}. The line-status codes (11 Z, 01 one, 10 zero, 00 invalid) pass through unchanged.
- R7: A tree_timeout pulse sets 0x6 bit 7 and a pwr_drop pulse sets 0x6 bit 6. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as its clear leaves the flag set.
- R8: A cfg_sent pulse clears the ping count and starts it. The count advances by one for each tick_50m while it runs. It stops at the first pkt_rcvd after the start, and later receptions are ignored. The value is held until the next cfg_sent and reads at 0x8 (high byte) and 0x9 (low byte). When cfg_sent and pkt_rcvd arrive together, the timer restarts.
- R9: The ping count saturates at 0xFFFF and does not wrap.
- R10: Read-only registers and reserved bits ignore writes. Reserved bits and unmapped addresses (0xA to 0xF) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| node_id | input | 6 | Node number from the core |
| is_root | input | 1 | Node is root |
| cable_pwr_ok | input | 1 | Cable power present |
| port_a_stat | input | 6 | Pair-A line status, 2 bits per port |
| port_b_stat | input | 6 | Pair-B line status, 2 bits per port |
| port_child | input | 3 | Port leads to a child |
| port_conn | input | 3 | Port connected |
| port_fast | input | 3 | Port supports the higher speed |
| slow_pin_n | input | 1 | Low forces slow mode |
| bus_reset_done | input | 1 | Pulse: bus reset completed |
| cfg_sent | input | 1 | Pulse: configuration packet sent |
| pkt_rcvd | input | 1 | Pulse: packet received |
| tree_timeout | input | 1 | Pulse: tree identification timed out |
| pwr_drop | input | 1 | Pulse: cable power dropped |
| tick_50m | input | 1 | Ping timer count enable |
| gap_count | output | 6 | Gap count to the core |
| hold_root | output | 1 | Root-holding request |
| bus_reset_req | output | 1 | Bus-reset request |
| arb_reset_req | output | 1 | Arbitrated bus-reset request |
| slow_mode | output | 1 | Node acts at the lower speed |

## Verification
An interrupt event and a software clear of the same flag can arrive in the same cycle. The bench provokes this by pulsing tree_timeout in the cycle that writes 1 to bit 7 of 0x6. It then reads the flag back and expects it still set, and a later plain clear must drop it. A completed bus reset can also coincide with a fresh write of the reset-request bit. The bench drives both in one cycle, expects the written value to stay, and checks it at the bus_reset_req port.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PT_IDLE = 2'd0,
        PT_RUN  = 2'd1,
        PT_HELD = 2'd2
    } ping_state_t;

    localparam logic [ADDR_W-1:0] A_NODE    = 4'h0;
    localparam logic [ADDR_W-1:0] A_BUS     = 4'h1;
    localparam logic [ADDR_W-1:0] A_CAP     = 4'h2;
    localparam logic [ADDR_W-1:0] A_PORT0   = 4'h3;
    localparam logic [ADDR_W-1:0] A_IRQ     = 4'h6;
    localparam logic [ADDR_W-1:0] A_MODE    = 4'h7;
    localparam logic [ADDR_W-1:0] A_PING_HI = 4'h8;
    localparam logic [ADDR_W-1:0] A_PING_LO = 4'h9;
endpackage

// File: rtl/phy_ping_timer.sv
module phy_ping_timer
    import phy_regbank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_sent,
    input  logic         pkt_rcvd,
    input  logic         tick,
    output logic [W-1:0] count,
    output ping_state_t  state
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    ping_state_t nxt;

    // next-state logic; a configuration packet outranks a reception (R8)
    always_comb begin
        nxt = state;
        unique case (state)
            PT_IDLE: if (cfg_sent) nxt = PT_RUN;
            PT_RUN: begin
                if (cfg_sent)      nxt = PT_RUN;
                else if (pkt_rcvd) nxt = PT_HELD;
            end
            PT_HELD: if (cfg_sent) nxt = PT_RUN;
            default: nxt = PT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PT_IDLE;
        else        state <= nxt;
    end

    // count output: clear on start, advance while running, saturate (R9)
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (cfg_sent)
            count <= '0;
        else if (state == PT_RUN && !pkt_rcvd && tick && count != MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/phy_irq_flags.sv
module phy_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // set outranks a same-cycle clear (R7)
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_ctrl_bits.sv
module phy_ctrl_bits #(
    parameter int          GAP_W    = 6,
    parameter logic [5:0]  GAP_INIT = 6'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_bus,
    input  logic [GAP_W+1:0] bus_byte,
    input  logic             wr_mode,
    input  logic             slow_wbit,
    input  logic             arb_wbit,
    input  logic             bus_reset_done,
    output logic [GAP_W-1:0] gap_count,
    output logic             hold_root,
    output logic             bus_reset_req,
    output logic             arb_reset_req,
    output logic             slow_bit
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_count     <= GAP_INIT;
            hold_root     <= 1'b0;
            bus_reset_req <= 1'b0;
        end else if (wr_bus) begin
            gap_count     <= bus_byte[GAP_W+1:2];
            hold_root     <= bus_byte[1];
            bus_reset_req <= bus_byte[0];
        end else if (bus_reset_done) begin
            bus_reset_req <= 1'b0;  // R3
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_bit      <= 1'b0;
            arb_reset_req <= 1'b0;
        end else if (wr_mode) begin
            slow_bit      <= slow_wbit;
            arb_reset_req <= arb_wbit;
        end else if (bus_reset_done) begin
            arb_reset_req <= 1'b0;  // R3
        end
    end
endmodule

// File: rtl/phy_regbank.sv
module phy_regbank
    import phy_regbank_pkg::*;
#(
    parameter int         NUM_PORTS = 3,
    parameter int         TIMER_W   = 16,
    parameter int         ID_W      = 6,
    parameter logic [5:0] GAP_INIT  = 6'h3F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [3:0]             addr,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    input  logic [ID_W-1:0]        node_id,
    input  logic                   is_root,
    input  logic                   cable_pwr_ok,
    input  logic [2*NUM_PORTS-1:0] port_a_stat,
    input  logic [2*NUM_PORTS-1:0] port_b_stat,
    input  logic [NUM_PORTS-1:0]   port_child,
    input  logic [NUM_PORTS-1:0]   port_conn,
    input  logic [NUM_PORTS-1:0]   port_fast,
    input  logic                   slow_pin_n,
    input  logic                   bus_reset_done,
    input  logic                   cfg_sent,
    input  logic                   pkt_rcvd,
    input  logic                   tree_timeout,
    input  logic                   pwr_drop,
    input  logic                   tick_50m,
    output logic [5:0]             gap_count,
    output logic                   hold_root,
    output logic                   bus_reset_req,
    output logic                   arb_reset_req,
    output logic                   slow_mode
);
    localparam int IRQ_N = 2;
    localparam int LOOP_IDX = 1;
    localparam int PWR_IDX = 0;

    logic               slow_bit;
    logic [IRQ_N-1:0]   irq_flags;
    logic [IRQ_N-1:0]   irq_set;
    logic [IRQ_N-1:0]   irq_clr;
    logic [TIMER_W-1:0] ping_count;
    ping_state_t        ping_state;
    logic [7:0]         port_byte [NUM_PORTS];
    logic [7:0]         rd_next;
    logic               wr_irq;

    phy_ctrl_bits #(.GAP_W(6), .GAP_INIT(GAP_INIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_bus(wr_en && addr == A_BUS), .bus_byte(wr_data),
        .wr_mode(wr_en && addr == A_MODE),
        .slow_wbit(wr_data[6]), .arb_wbit(wr_data[5]),
        .bus_reset_done(bus_reset_done),
        .gap_count(gap_count), .hold_root(hold_root),
        .bus_reset_req(bus_reset_req), .arb_reset_req(arb_reset_req),
        .slow_bit(slow_bit)
    );

    assign wr_irq = wr_en && addr == A_IRQ;
    assign irq_set[LOOP_IDX] = tree_timeout;
    assign irq_set[PWR_IDX]  = pwr_drop;
    assign irq_clr[LOOP_IDX] = wr_irq && wr_data[7];
    assign irq_clr[PWR_IDX]  = wr_irq && wr_data[6];

    phy_irq_flags #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .flags(irq_flags)
    );

    phy_ping_timer #(.W(TIMER_W)) u_ping (
        .clk(clk), .rst_n(rst_n), .cfg_sent(cfg_sent), .pkt_rcvd(pkt_rcvd),
        .tick(tick_50m), .count(ping_count), .state(ping_state)
    );

    assign slow_mode = slow_bit || !slow_pin_n;  // R4

    for (genvar n = 0; n < NUM_PORTS; n++) begin : g_port
        assign port_byte[n] = {port_a_stat[2*n +: 2], port_b_stat[2*n +: 2],
                               port_child[n], port_conn[n], port_fast[n], 1'b0};
    end

    always_comb begin
        rd_next = '0;  // unmapped addresses read 0 (R10)
        unique case (addr)
            A_NODE:    rd_next = {node_id, is_root, cable_pwr_ok};
            A_BUS:     rd_next = {gap_count, hold_root, bus_reset_req};
            A_CAP:     rd_next = {slow_mode ? 2'b00 : 2'b01, 1'b0, 5'(NUM_PORTS)};
            A_IRQ:     rd_next = {irq_flags[LOOP_IDX], irq_flags[PWR_IDX], cable_pwr_ok, 5'b0};
            A_MODE:    rd_next = {!slow_pin_n, slow_bit, arb_reset_req, 5'b0};
            A_PING_HI: rd_next = ping_count[TIMER_W-1 -: 8];
            A_PING_LO: rd_next = ping_count[7:0];
            default: begin
                for (int n = 0; n < NUM_PORTS; n++)
                    if (addr == 4'(int'(A_PORT0) + n)) rd_next = port_byte[n];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;  // R2
    end
endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk
    import phy_regbank_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rd_en,
    input logic         wr_en,
    input logic [3:0]   addr,
    input logic [7:0]   rd_data,
    input logic         bus_reset_done,
    input logic         bus_reset_req,
    input logic         arb_reset_req,
    input logic         tree_timeout,
    input logic         pwr_drop,
    input logic [1:0]   flags,
    input ping_state_t  ping_state,
    input logic [W-1:0] ping_count,
    input logic         cfg_sent,
    input logic         slow_pin_n,
    input logic         slow_mode
);
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    a_r3_ibr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_done && !(wr_en && addr == A_BUS) |=> !bus_reset_req);
    a_r3_arb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_done && !(wr_en && addr == A_MODE) |=> !arb_reset_req);
    a_r4_pin_slow: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_pin_n |-> slow_mode);
    a_r7_loop_set: assert property (@(posedge clk) disable iff (!rst_n)
        tree_timeout |=> flags[1]);
    a_r7_pwr_set: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_drop |=> flags[0]);
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sent |=> ping_count == '0 && ping_state == PT_RUN);
    a_r8_held: assert property (@(posedge clk) disable iff (!rst_n)
        ping_state == PT_HELD && !cfg_sent |=> $stable(ping_count));
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ping_count == {W{1'b1}} && !cfg_sent |=> ping_count == {W{1'b1}});
endmodule

bind phy_regbank phy_regbank_chk #(.W(TIMER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .rd_data(rd_data), .bus_reset_done(bus_reset_done),
    .bus_reset_req(bus_reset_req), .arb_reset_req(arb_reset_req),
    .tree_timeout(tree_timeout), .pwr_drop(pwr_drop), .flags(irq_flags),
    .ping_state(ping_state), .ping_count(ping_count), .cfg_sent(cfg_sent),
    .slow_pin_n(slow_pin_n), .slow_mode(slow_mode)
);

// File: tb/test_phy_regbank.sv
module test_phy_regbank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 0, wr_en = 0;
    logic [3:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic bus_reset_done = 0, cfg_sent = 0, pkt_rcvd = 0;
    logic tree_timeout = 0, pwr_drop = 0, tick_50m = 0;
    logic slow_pin_n = 1'b1;
    logic [5:0] gap_count;
    logic hold_root, bus_reset_req, arb_reset_req, slow_mode;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    phy_regbank i_phy_regbank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .node_id(6'h2A), .is_root(1'b1),
        .cable_pwr_ok(1'b1), .port_a_stat(6'b11_01_10), .port_b_stat(6'b00_10_11),
        .port_child(3'b010), .port_conn(3'b111), .port_fast(3'b001),
        .slow_pin_n(slow_pin_n), .bus_reset_done(bus_reset_done),
        .cfg_sent(cfg_sent), .pkt_rcvd(pkt_rcvd), .tree_timeout(tree_timeout),
        .pwr_drop(pwr_drop), .tick_50m(tick_50m), .gap_count(gap_count),
        .hold_root(hold_root), .bus_reset_req(bus_reset_req),
        .arb_reset_req(arb_reset_req), .slow_mode(slow_mode)
    );

    // {req[3:0], write, addr[3:0], data-or-expected[7:0]}
    localparam int NV = 22;
    localparam logic [16:0] TBL [NV] = '{
        {4'd10, 1'b0, 4'h0, 8'hAB},  // R10 node byte
        {4'd1,  1'b0, 4'h1, 8'hFC},  // R1 gap reset value
        {4'd4,  1'b0, 4'h2, 8'h43},  // R4 speed 01, ports 3
        {4'd6,  1'b0, 4'h3, 8'hB6},  // R6 port 0
        {4'd6,  1'b0, 4'h4, 8'h6C},  // R6 port 1
        {4'd6,  1'b0, 4'h5, 8'hC4},  // R6 port 2
        {4'd1,  1'b0, 4'h6, 8'h20},  // R1 flags clear
        {4'd1,  1'b0, 4'h7, 8'h00},
        {4'd1,  1'b0, 4'h8, 8'h00},  // R1 ping idle
        {4'd1,  1'b0, 4'h9, 8'h00},
        {4'd10, 1'b0, 4'hF, 8'h00},
        {4'd2,  1'b1, 4'h1, 8'h4A},
        {4'd2,  1'b0, 4'h1, 8'h4A},  // R2 write/read back
        {4'd5,  1'b1, 4'h7, 8'hFF},
        {4'd5,  1'b0, 4'h7, 8'h60},  // R5 slow, arb; reserved stay 0
        {4'd4,  1'b0, 4'h2, 8'h03},  // R4 slow bit drops speed
        {4'd5,  1'b1, 4'h7, 8'h00},
        {4'd5,  1'b0, 4'h7, 8'h00},
        {4'd10, 1'b1, 4'h0, 8'hFF},
        {4'd10, 1'b0, 4'h0, 8'hAB},  // R10 read-only
        {4'd10, 1'b1, 4'hC, 8'hFF},
        {4'd10, 1'b0, 4'hC, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rd_data;
    endtask

    task automatic ping_read(output logic [15:0] v);
        logic [7:0] h, l;
        rd(4'h8, h); rd(4'h9, l);
        v = {h, l};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic [15:0] pv;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rd_data", {8'h0, rd_data}, 16'h0000);
        chk("R1 gap_count", {10'h0, gap_count}, 16'h003F);
        chk("R1 ctrl", {12'h0, hold_root, bus_reset_req, arb_reset_req, slow_mode}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][12]) wr(TBL[i][11:8], TBL[i][7:0]);
            else begin
                rd(TBL[i][11:8], b);
                total++;
                if (b !== TBL[i][7:0]) begin
                    bad++;
                    $display("FAIL R%0d table[%0d] actual=%h expected=%h",
                             TBL[i][16:13], i, b, TBL[i][7:0]);
                end
            end
        end

        // R3 reset requests clear on completed bus reset
        wr(4'h1, 8'h03);
        wr(4'h7, 8'h20);
        chk("R3 set", {14'h0, bus_reset_req, arb_reset_req}, 16'h3);
        @(negedge clk); bus_reset_done = 1;
        @(negedge clk); bus_reset_done = 0;
        chk("R3 cleared", {13'h0, hold_root, bus_reset_req, arb_reset_req}, 16'h4);
        @(negedge clk); bus_reset_done = 1; wr_en = 1; addr = 4'h1; wr_data = 8'h01;
        @(negedge clk); bus_reset_done = 0; wr_en = 0;
        chk("R3 write wins", {15'h0, bus_reset_req}, 16'h1);

        // R7 interrupt flags
        @(negedge clk); tree_timeout = 1;
        @(negedge clk); tree_timeout = 0;
        rd(4'h6, b); chk("R7 loop set", {8'h0, b}, 16'h00A0);
        @(negedge clk); pwr_drop = 1;
        @(negedge clk); pwr_drop = 0;
        rd(4'h6, b); chk("R7 power set", {8'h0, b}, 16'h00E0);
        wr(4'h6, 8'h40);
        rd(4'h6, b); chk("R7 clear one", {8'h0, b}, 16'h00A0);
        wr(4'h6, 8'h00);
        rd(4'h6, b); chk("R7 zero no effect", {8'h0, b}, 16'h00A0);
        @(negedge clk); tree_timeout = 1; wr_en = 1; addr = 4'h6; wr_data = 8'h80;
        @(negedge clk); tree_timeout = 0; wr_en = 0;
        rd(4'h6, b); chk("R7 set wins", {8'h0, b}, 16'h00A0);
        wr(4'h6, 8'h80);
        rd(4'h6, b); chk("R7 cleared", {8'h0, b}, 16'h0020);

        // R8 ping timer
        @(negedge clk); cfg_sent = 1;
        @(negedge clk); cfg_sent = 0; tick_50m = 1;
        repeat (37) @(negedge clk);
        tick_50m = 0; pkt_rcvd = 1;
        @(negedge clk); pkt_rcvd = 0;
        ping_read(pv); chk("R8 stop value", pv, 16'd37);
        tick_50m = 1;
        repeat (10) @(negedge clk);
        pkt_rcvd = 1;
        @(negedge clk); pkt_rcvd = 0; tick_50m = 0;
        ping_read(pv); chk("R8 held", pv, 16'd37);
        @(negedge clk); cfg_sent = 1; pkt_rcvd = 1;
        @(negedge clk); cfg_sent = 0; pkt_rcvd = 0;
        ping_read(pv); chk("R8 restart clears", pv, 16'd0);
        tick_50m = 1;
        repeat (5) @(negedge clk);
        tick_50m = 0;
        ping_read(pv); chk("R8 runs after restart", pv, 16'd5);

        // R9 saturation
        @(negedge clk); cfg_sent = 1;
        @(negedge clk); cfg_sent = 0; tick_50m = 1;
        repeat (65540) @(negedge clk);
        tick_50m = 0;
        ping_read(pv); chk("R9 saturate", pv, 16'hFFFF);

        // R4/R5 slow pin
        slow_pin_n = 0;
        rd(4'h2, b); chk("R4 pin slow speed", {8'h0, b}, 16'h0003);
        rd(4'h7, b); chk("R5 pin readable", {8'h0, b}, 16'h0080);
        chk("R4 slow_mode", {15'h0, slow_mode}, 16'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule